// File: doc/BRIEF.md
# Transmit Packet Buffer

This block holds outgoing frames between a host write port and a byte-oriented MAC transmitter. The host writes the frame body as 32-bit words into a data queue and then writes one descriptor word into a separate descriptor queue. The descriptor gives the frame length in bytes and the position of the first valid byte inside the first word. The first word can therefore start in the middle.

On the MAC side the block takes one descriptor at a time and skips the leading pad bytes of the first word. It then delivers exactly the described number of bytes as a valid/ready byte stream, with markers on the first and the last byte. Consumed words leave the data queue as they are used up. The host sees the number of occupied data words, an almost-empty flag compared against a level it supplies, and sticky flags for pushes that were dropped. A flush input clears everything while it is held.

Top module: `tx_pkt_buffer`

## Requirements
- R1: After reset, data_words is 0, byte_valid is 0, both overflow flags are 0 and almost_empty is 1.
- R2: A descriptor word carries the byte count in bits 15:0 and the starting byte position in bits 17:16. The stream carries exactly that many bytes, starting at that position in the first word. Byte k of a word is bits 8k+7:8k, and bytes leave lowest position first.
- R3: A frame of length L and start position P removes exactly (L+P+3)>>2 words from the data queue. The next frame begins at the following word, so data_words returns to 0 when every queued frame has been sent.
- R4: No byte is offered while the descriptor queue is empty, even if data words are waiting.
- R5: byte_first is 1 on the first byte of a frame and byte_last is 1 on its last byte. A one-byte frame has both on the same byte.
- R6: While byte_valid is 1 and byte_ready is 0, byte_valid, byte_data, byte_first and byte_last hold their values.
- R7: data_words shows the number of occupied data words. It changes in the cycle after an accepted push or pop.
- R8: almost_empty is 1 exactly when data_words is less than or equal to ae_level.
- R9: A push into a full queue is dropped and the queue contents are unchanged. It sets that queue's overflow flag (data_ovf or cmd_ovf), and the flag stays set until reset or flush.
- R10: While flush is 1, both queues are empty, the overflow flags are 0, pushes are ignored and no byte is offered. A frame in progress is abandoned.
- R11: A descriptor with length 0 produces no bytes and discards (P+3)>>2 data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empties both queues while held at 1 |
| data_push | input | 1 | Push data_in into the data queue |
| data_in | input | 32 | Frame data word |
| cmd_push | input | 1 | Push cmd_in into the descriptor queue |
| cmd_in | input | 32 | Descriptor: length in 15:0, start position in 17:16 |
| ae_level | input | CNT_W | Almost-empty comparison level |
| data_words | output | CNT_W | Occupied data words |
| almost_empty | output | 1 | data_words is at or below ae_level |
| data_ovf | output | 1 | Sticky: a data push was dropped |
| cmd_ovf | output | 1 | Sticky: a descriptor push was dropped |
| byte_valid | output | 1 | A stream byte is offered |
| byte_ready | input | 1 | The MAC accepts the offered byte |
| byte_data | output | 8 | Stream byte |
| byte_first | output | 1 | Offered byte is the first of its frame |
| byte_last | output | 1 | Offered byte is the last of its frame |

## Verification
The hardest state to reach is a full descriptor queue. The unpacker takes descriptors whenever it is idle, so the queue only fills when the unpacker is stuck in the middle of a frame. The bench gets there by holding byte_ready low once a long frame has started, filling the data queue past its depth, and then pushing more descriptors than the queue holds. Flush is then applied with a push pending on the same edge, to confirm that it abandons the stalled frame and ignores that push. Zero-length descriptors with a nonzero start position are placed just before a normal frame, so any wrong word discard shows up as corrupted bytes in the frame that follows.

// File: rtl/tx_pkt_pkg.sv
package tx_pkt_pkg;

    // Descriptor layout written by the host after the frame body
    typedef struct packed {
        logic [13:0] spare;
        logic [1:0]  start_pos;
        logic [15:0] byte_len;
    } txdesc_t;

    typedef enum logic [1:0] {
        UNP_IDLE = 2'd0,
        UNP_SEND = 2'd1,
        UNP_SKIP = 2'd2
    } unp_state_e;

endpackage

// File: rtl/txb_fifo.sv
module txb_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full,
    output logic             overflow
);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic          ovf;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic wr_en;
    logic rd_en;
    logic is_full;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) begin
            return '0;
        end
        return p + AW'(1);
    endfunction

    assign is_full = (q.count == CW'(DEPTH));

    always_comb begin
        d     = q;
        wr_en = push && !is_full && !flush;
        rd_en = pop && (q.count != '0) && !flush;
        if (flush) begin
            d = '0;
        end else begin
            if (push && is_full) begin
                d.ovf = 1'b1;
            end
            if (wr_en) begin
                d.wr_ptr = bump(q.wr_ptr);
            end
            if (rd_en) begin
                d.rd_ptr = bump(q.rd_ptr);
            end
            case ({wr_en, rd_en})
                2'b10:   d.count = q.count + CW'(1);
                2'b01:   d.count = q.count - CW'(1);
                default: d.count = q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[q.wr_ptr] <= push_data;
        end
    end

    assign head     = mem[q.rd_ptr];
    assign count    = q.count;
    assign empty    = (q.count == '0);
    assign full     = is_full;
    assign overflow = q.ovf;

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (count == $past(count)) && overflow) // R9
        else $error("push into full queue changed its contents");

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow) // R9
        else $error("overflow flag dropped without flush");

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !overflow)) // R10
        else $error("flush left queue occupied");

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> ((count == $past(count)) || (count == $past(count) + CW'(1))
                    || (count + CW'(1) == $past(count)))) // R7
        else $error("occupancy moved by more than one");

endmodule

// File: rtl/txb_unpack.sv
module txb_unpack
    import tx_pkt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  txdesc_t     desc_head,
    input  logic        desc_empty,
    input  logic [31:0] word_head,
    input  logic        word_empty,
    output logic        desc_pop,
    output logic        word_pop,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic        out_first,
    output logic        out_last
);

    typedef struct packed {
        unp_state_e  st;
        logic [15:0] remain;
        logic [1:0]  idx;
        logic        first;
    } unp_st_t;

    localparam unp_st_t UNP_RESET = '{st: UNP_IDLE, remain: 16'd0, idx: 2'd0, first: 1'b0};

    unp_st_t q, d;

    always_comb begin
        d         = q;
        desc_pop  = 1'b0;
        word_pop  = 1'b0;
        out_valid = 1'b0;
        if (flush) begin
            d = UNP_RESET;
        end else begin
            case (q.st)
                UNP_IDLE: begin
                    if (!desc_empty) begin
                        desc_pop = 1'b1;
                        if (desc_head.byte_len != 16'd0) begin
                            d.st     = UNP_SEND;
                            d.remain = desc_head.byte_len;
                            d.idx    = desc_head.start_pos;
                            d.first  = 1'b1;
                        end else if (desc_head.start_pos != 2'd0) begin
                            d.st = UNP_SKIP;
                        end
                    end
                end
                UNP_SEND: begin
                    out_valid = !word_empty;
                    if (out_valid && out_ready) begin
                        d.first  = 1'b0;
                        d.remain = q.remain - 16'd1;
                        d.idx    = q.idx + 2'd1;
                        if ((q.idx == 2'd3) || (q.remain == 16'd1)) begin
                            word_pop = 1'b1;
                        end
                        if (q.remain == 16'd1) begin
                            d.st = UNP_IDLE;
                        end
                    end
                end
                UNP_SKIP: begin
                    if (!word_empty) begin
                        word_pop = 1'b1;
                        d.st     = UNP_IDLE;
                    end
                end
                default: d = UNP_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= UNP_RESET;
        end else begin
            q <= d;
        end
    end

    assign out_data  = word_head[{q.idx, 3'b000} +: 8];
    assign out_first = out_valid && q.first;
    assign out_last  = out_valid && (q.remain == 16'd1);

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (flush || (out_valid && $stable(out_data)
            && $stable(out_first) && $stable(out_last)))) // R6
        else $error("stream changed while stalled");

    AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_first) |=> !out_first) // R5
        else $error("two first markers in a row");

    AST_WAIT_FOR_DESC: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_empty && (q.st == UNP_IDLE)) |=> !out_valid) // R4
        else $error("byte offered without a descriptor");

    AST_POP_HAS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        word_pop |-> !word_empty) // R3
        else $error("word popped from empty queue");

endmodule

// File: rtl/tx_pkt_buffer.sv
module tx_pkt_buffer
    import tx_pkt_pkg::*;
#(
    parameter int DATA_DEPTH = 512,
    parameter int CMD_DEPTH  = 16,
    localparam int CNT_W     = $clog2(DATA_DEPTH + 1),
    localparam int CMD_CW    = $clog2(CMD_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             data_push,
    input  logic [31:0]      data_in,
    input  logic             cmd_push,
    input  logic [31:0]      cmd_in,
    input  logic [CNT_W-1:0] ae_level,
    output logic [CNT_W-1:0] data_words,
    output logic             almost_empty,
    output logic             data_ovf,
    output logic             cmd_ovf,
    output logic             byte_valid,
    input  logic             byte_ready,
    output logic [7:0]       byte_data,
    output logic             byte_first,
    output logic             byte_last
);

    logic [31:0]       word_head;
    logic              word_empty;
    logic              word_full;
    logic              word_pop;
    logic [31:0]       desc_raw;
    txdesc_t           desc_head;
    logic              desc_empty;
    logic              desc_full;
    logic              desc_pop;
    logic [CMD_CW-1:0] desc_count;

    txb_fifo #(.WIDTH(32), .DEPTH(DATA_DEPTH)) u_word_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (data_push),
        .push_data (data_in),
        .pop       (word_pop),
        .head      (word_head),
        .count     (data_words),
        .empty     (word_empty),
        .full      (word_full),
        .overflow  (data_ovf)
    );

    txb_fifo #(.WIDTH(32), .DEPTH(CMD_DEPTH)) u_desc_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (cmd_push),
        .push_data (cmd_in),
        .pop       (desc_pop),
        .head      (desc_raw),
        .count     (desc_count),
        .empty     (desc_empty),
        .full      (desc_full),
        .overflow  (cmd_ovf)
    );

    assign desc_head = txdesc_t'(desc_raw);

    txb_unpack u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .desc_head  (desc_head),
        .desc_empty (desc_empty),
        .word_head  (word_head),
        .word_empty (word_empty),
        .desc_pop   (desc_pop),
        .word_pop   (word_pop),
        .out_valid  (byte_valid),
        .out_ready  (byte_ready),
        .out_data   (byte_data),
        .out_first  (byte_first),
        .out_last   (byte_last)
    );

    assign almost_empty = (data_words <= ae_level);

    AST_QUEUES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (data_words <= CNT_W'(DATA_DEPTH)) && (desc_count <= CMD_CW'(CMD_DEPTH))
        && !(word_full && word_empty) && !(desc_full && desc_empty)) // R9
        else $error("queue occupancy out of range");

endmodule

// File: tb/tb_tx_pkt_buffer.sv
module tb_tx_pkt_buffer;

    localparam int DD = 8;
    localparam int CD = 4;
    localparam int CW = $clog2(DD + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          data_push = 1'b0;
    logic [31:0]   data_in = '0;
    logic          cmd_push = 1'b0;
    logic [31:0]   cmd_in = '0;
    logic [CW-1:0] ae_level = '0;
    logic [CW-1:0] data_words;
    logic          almost_empty;
    logic          data_ovf;
    logic          cmd_ovf;
    logic          byte_valid;
    logic          byte_ready = 1'b1;
    logic [7:0]    byte_data;
    logic          byte_first;
    logic          byte_last;

    tx_pkt_buffer #(.DATA_DEPTH(DD), .CMD_DEPTH(CD)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .data_push(data_push), .data_in(data_in),
        .cmd_push(cmd_push), .cmd_in(cmd_in),
        .ae_level(ae_level), .data_words(data_words), .almost_empty(almost_empty),
        .data_ovf(data_ovf), .cmd_ovf(cmd_ovf),
        .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
        .byte_first(byte_first), .byte_last(byte_last)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    bit bp_on = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    logic [7:0] cap_data [512];
    logic       cap_first [512];
    logic       cap_last [512];
    int         cap_n = 0;

    // Table: {length, start position, seed, random backpressure}
    localparam logic [31:0] VEC [0:6] = '{
        32'h01_00_0A_00, 32'h04_00_14_00, 32'h05_03_1E_00, 32'h07_01_28_01,
        32'h0D_02_32_01, 32'h02_03_3C_00, 32'h01_03_46_01
    };

    always @(negedge clk) begin
        if (rst_n && byte_valid && byte_ready && cap_n < 512) begin
            cap_data[cap_n]  = byte_data;
            cap_first[cap_n] = byte_first;
            cap_last[cap_n]  = byte_last;
            cap_n = cap_n + 1;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (bp_on) begin
                byte_ready = lfsr[0];
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] word_of(input int seed, input int j);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) begin
            w[8*k +: 8] = 8'(seed + 4 * j + k);
        end
        return w;
    endfunction

    task automatic push_word(input logic [31:0] w);
        @(negedge clk);
        data_push = 1'b1;
        data_in   = w;
        @(negedge clk);
        data_push = 1'b0;
    endtask

    task automatic push_cmd(input int len, input int pos);
        @(negedge clk);
        cmd_push = 1'b1;
        cmd_in   = {14'd0, 2'(pos), 16'(len)};
        @(negedge clk);
        cmd_push = 1'b0;
    endtask

    task automatic load_frame(input int len, input int pos, input int seed);
        int nw;
        nw = (len + pos + 3) >> 2;
        for (int j = 0; j < nw; j++) begin
            push_word(word_of(seed, j));
        end
    endtask

    task automatic check_frame(input int base, input int len, input int pos, input int seed);
        int errs;
        int first_bad;
        int marks_ok;
        errs = 0;
        first_bad = -1;
        marks_ok = 1;
        for (int t = 0; t < 800 && cap_n < base + len; t++) begin
            @(negedge clk);
        end
        tick(6);
        chk(cap_n == base + len, "R2", "byte count", cap_n - base, len);
        for (int i = 0; i < len && base + i < 512; i++) begin
            if (cap_data[base + i] !== 8'(seed + pos + i)) begin
                errs++;
                if (first_bad < 0) first_bad = i;
            end
            if (cap_first[base + i] !== (i == 0)) marks_ok = 0;
            if (cap_last[base + i] !== (i == len - 1)) marks_ok = 0;
        end
        if (first_bad >= 0) begin
            chk(1'b0, "R2", "byte value", int'(cap_data[base + first_bad]),
                int'(8'(seed + pos + first_bad)));
        end else begin
            chk(1'b1, "R2", "byte value", 0, 0);
        end
        chk(marks_ok == 1, "R5", "first/last markers", marks_ok, 1);
        chk(data_words == '0, "R3", "words left after frame", int'(data_words), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk(data_words == '0, "R1", "data_words", int'(data_words), 0);
        chk(!byte_valid, "R1", "byte_valid", int'(byte_valid), 0);
        chk(!data_ovf && !cmd_ovf, "R1", "overflow flags", int'({data_ovf, cmd_ovf}), 0);
        chk(almost_empty, "R1", "almost_empty", int'(almost_empty), 1);

        // Table-driven frames (R2, R3, R5, R6 under random stalls)
        for (int v = 0; v < 7; v++) begin
            bp_on = VEC[v][0];
            base = cap_n;
            load_frame(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]));
            push_cmd(int'(VEC[v][31:24]), int'(VEC[v][23:16]));
            check_frame(base, int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]));
            bp_on = 1'b0;
            tick(1);
            byte_ready = 1'b1;
        end

        // R4, R7, R8: data waiting without descriptor
        ae_level = CW'(2);
        push_word(word_of(90, 0));
        push_word(word_of(90, 1));
        tick(4);
        chk(!byte_valid, "R4", "no byte without descriptor", int'(byte_valid), 0);
        chk(data_words == CW'(2), "R7", "two words queued", int'(data_words), 2);
        chk(almost_empty, "R8", "almost_empty at level", int'(almost_empty), 1);
        push_word(word_of(90, 2));
        chk(data_words == CW'(3), "R7", "count after push", int'(data_words), 3);
        chk(!almost_empty, "R8", "almost_empty above level", int'(almost_empty), 0);
        base = cap_n;
        push_cmd(10, 1);
        check_frame(base, 10, 1, 90);

        // R6: directed stall on the first byte
        byte_ready = 1'b0;
        base = cap_n;
        load_frame(6, 0, 100);
        push_cmd(6, 0);
        for (int t = 0; t < 50 && !byte_valid; t++) @(negedge clk);
        tick(3);
        chk(byte_valid && byte_first && byte_data == 8'd100, "R6", "held first byte",
            int'(byte_data), 100);
        byte_ready = 1'b1;
        check_frame(base, 6, 0, 100);

        // R11: zero-length descriptors
        base = cap_n;
        push_word(word_of(120, 0));
        push_cmd(0, 2);
        tick(4);
        chk(data_words == '0, "R11", "pad word discarded", int'(data_words), 0);
        chk(cap_n == base, "R11", "no bytes for empty frame", cap_n - base, 0);
        load_frame(3, 0, 130);
        push_cmd(3, 0);
        check_frame(base, 3, 0, 130);
        base = cap_n;
        push_cmd(0, 0);
        tick(4);
        chk(cap_n == base && !byte_valid, "R11", "zero length at position 0", cap_n - base, 0);

        // R9: overflow of both queues with the unpacker stalled
        byte_ready = 1'b0;
        for (int j = 0; j < DD + 1; j++) push_word(word_of(150, j));
        chk(data_words == CW'(DD), "R9", "data queue capped", int'(data_words), DD);
        chk(data_ovf, "R9", "data overflow flag", int'(data_ovf), 1);
        push_cmd(32, 0);
        tick(3);
        chk(byte_valid && byte_data == 8'd150, "R9", "stalled frame head", int'(byte_data), 150);
        for (int j = 0; j < CD + 1; j++) push_cmd(4, 0);
        chk(cmd_ovf, "R9", "descriptor overflow flag", int'(cmd_ovf), 1);
        tick(5);
        chk(data_ovf && cmd_ovf, "R9", "flags sticky", int'({data_ovf, cmd_ovf}), 3);

        // R10: flush with a simultaneous push
        @(negedge clk);
        flush = 1'b1;
        data_push = 1'b1;
        data_in = 32'hDEAD_BEEF;
        @(negedge clk);
        data_push = 1'b0;
        chk(data_words == '0 && !byte_valid, "R10", "flush empties", int'(data_words), 0);
        chk(!data_ovf && !cmd_ovf, "R10", "flush clears flags", int'({data_ovf, cmd_ovf}), 0);
        tick(2);
        flush = 1'b0;
        tick(3);
        chk(data_words == '0 && !byte_valid, "R10", "nothing left after flush",
            int'(data_words), 0);
        byte_ready = 1'b1;
        base = cap_n;
        load_frame(5, 0, 170);
        push_cmd(5, 0);
        check_frame(base, 5, 0, 170);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule